// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the read path of a two-bank flash array controller. While a program or erase runs inside the array, the host keeps issuing ordinary reads. The block decides, read by read, whether to return the word the array supplies or a status word. That status word carries a polling bit, a toggle bit that flips on every status read, and a second toggle bit that marks the sectors being erased. The block also drives an active-high ready output, which is low while an operation owns the array.

The command decoder tells the block when an operation starts, which address it targets and, for an erase, which sectors it covers. The cell-timing engine reports when the operation is finished, and the decoder also passes on erase suspend and resume. A parameter places the boundary between the two banks. Reads aimed at the bank that is not busy go straight through with the same one-cycle latency as any other read. An erase can be suspended: the host may then read sectors that are not being erased, while reads of the erasing sectors still show that the erase is held.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, ready_o is 1, no operation is active, and a read returns array_data_i.
- R2: A read strobe loads rd_data_o on the next rising clock edge, and rd_data_o holds its value while no strobe is present. A read issued in the same cycle as an accepted start still returns array data.
- R3: A status word has bit 7 as the polling bit, bit 6 as the operation toggle and bit 2 as the erase toggle. Every other bit reads 0. During a program, bit 7 is the inverse of bit 7 of the word being programmed and bit 2 reads 0.
- R4: Each status read of the busy bank during a running program or erase returns bit 6 and then inverts it. The first status read after an accepted start returns bit 6 = 0.
- R5: During a running program or erase, a read of the other bank returns array_data_i.
- R6: During a running erase, bit 7 reads 0. Bit 2 inverts after each read of a sector in the erase set. Bit 2 keeps its value on reads of other sectors of the busy bank, although bit 6 still inverts.
- R7: ready_o goes to 0 in the cycle after an accepted start and returns to 1 in the cycle after op_done_i.
- R8: A read in the same cycle as op_done_i still returns status. Reads after that return array data.
- R9: A suspend during a running erase sets ready_o to 1. A read of an erasing sector then returns bit 7 = 1 and an unchanged bit 6, while bit 2 keeps inverting. A read of any other sector returns array data.
- R10: A resume from suspend sets ready_o to 0 again, and bit 6 resumes inverting on reads of the busy bank.
- R11: abort_i ends any operation on the next edge. It sets ready_o to 1, returns reads to array data and clears both toggle bits.
- R12: Start requests are ignored while an operation is active or suspended. op_done_i is ignored while idle or suspended, and suspend or resume is ignored while idle.
- R13: Bank 0 holds the addresses below 2^ADDR_W x F / 64, where F is 1, 8, 16 or 32 for BANK_SEL 0 to 3. The default is ADDR_W 21 and BANK_SEL 2, which puts the boundary at 0x80000. The sector number is the top SECT_W address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| abort_i | input | 1 | Synchronous abort of any operation |
| prog_start_i | input | 1 | Program operation begins |
| erase_start_i | input | 1 | Erase operation begins |
| op_addr_i | input | ADDR_W | Target address of the starting operation |
| prog_data_i | input | DATA_W | Word being programmed |
| erase_sect_i | input | 2^SECT_W | One bit per sector in the erase set |
| op_done_i | input | 1 | Array reports the operation finished |
| suspend_i | input | 1 | Erase suspend request |
| resume_i | input | 1 | Erase resume request |
| rd_strobe_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | DATA_W | Array word for rd_addr_i |
| rd_data_o | output | DATA_W | Read result, one cycle after the strobe |
| ready_o | output | 1 | 1 when the array is ready, 0 while an operation runs |

## Verification
Two coincidences matter most. The first is a read strobe in the same cycle as op_done_i: the bench raises both together and expects the status word, with ready_o already 1 on the same edge, and array data on the next read. The second is a start request that arrives while a program is running. It is judged through the polling and toggle bits on the next read: an accepted restart would invert bit 7 and clear bit 6. Suspend is treated the same way. An op_done_i during suspend must leave ready_o and the erase-toggle sequence unchanged.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2,
    ST_ESUSP = 2'd3
  } op_state_t;

  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_ETOG = 2;
endpackage

// File: rtl/fstat_rst_sync.sv
module fstat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/fstat_addr_map.sv
module fstat_addr_map #(
  parameter int ADDR_W   = 21,
  parameter int SECT_W   = 6,
  parameter int BANK_SEL = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bank_o,
  output logic [SECT_W-1:0] sect_o
);
  localparam int FRAC = (BANK_SEL == 0) ? 1 :
                        (BANK_SEL == 1) ? 8 :
                        (BANK_SEL == 2) ? 16 : 32;
  localparam logic [ADDR_W-1:0] BOUND = ADDR_W'(FRAC) << (ADDR_W - 6);

  always_comb begin
    bank_o = (addr_i >= BOUND);
    sect_o = addr_i[ADDR_W-1 -: SECT_W];
  end
endmodule

// File: rtl/fstat_ctrl.sv
module fstat_ctrl
  import fstat_pkg::*;
#(
  parameter int N_SECT = 64
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              abort_i,
  input  logic              prog_start_i,
  input  logic              erase_start_i,
  input  logic              op_bank_i,
  input  logic              prog_bit_i,
  input  logic [N_SECT-1:0] erase_sect_i,
  input  logic              op_done_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  output op_state_t         state_o,
  output logic              op_bank_o,
  output logic              prog_bit_o,
  output logic [N_SECT-1:0] sect_mask_o,
  output logic              load_o,
  output logic              ready_o
);
  op_state_t         st_q, st_nx;
  logic              load;
  logic              go_idle;
  logic              mask_en;
  logic [N_SECT-1:0] mask_d;
  logic              bank_q, pbit_q;
  logic [N_SECT-1:0] mask_q;

  always_comb begin
    st_nx = st_q;
    load  = 1'b0;
    if (abort_i) begin
      st_nx = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (prog_start_i) begin
            st_nx = ST_PROG;
            load  = 1'b1;
          end else if (erase_start_i) begin
            st_nx = ST_ERASE;
            load  = 1'b1;
          end
        end
        ST_PROG:  if (op_done_i) st_nx = ST_IDLE;
        ST_ERASE: begin
          if (op_done_i)      st_nx = ST_IDLE;
          else if (suspend_i) st_nx = ST_ESUSP;
        end
        ST_ESUSP: if (resume_i) st_nx = ST_ERASE;
        default:  st_nx = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    go_idle = (st_nx == ST_IDLE) && (st_q != ST_IDLE);
    mask_en = load || go_idle;
    mask_d  = (load && !prog_start_i) ? erase_sect_i : '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= ST_IDLE;
    else         st_q <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      bank_q <= 1'b0;
      pbit_q <= 1'b0;
    end else if (load) begin
      bank_q <= op_bank_i;
      pbit_q <= prog_bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign state_o     = st_q;
  assign op_bank_o   = bank_q;
  assign prog_bit_o  = pbit_q;
  assign sect_mask_o = mask_q;
  assign load_o      = load;
  assign ready_o     = !((st_q == ST_PROG) || (st_q == ST_ERASE));

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_IDLE && !abort_i && (prog_start_i || erase_start_i)) |=> !ready_o);

  assert_done_ready_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    ((st_q == ST_PROG || st_q == ST_ERASE) && op_done_i) |=> ready_o);

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    abort_i |=> (ready_o && st_q == ST_IDLE));

  assert_susp_ready_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_ERASE && suspend_i && !op_done_i && !abort_i) |=> ready_o);
endmodule

// File: rtl/fstat_toggle.sv
module fstat_toggle (
  input  logic clk,
  input  logic rst_sn,
  input  logic clr_i,
  input  logic flip6_i,
  input  logic flip2_i,
  output logic tog6_o,
  output logic tog2_o
);
  logic tog6_q, tog2_q;
  logic en6, en2;
  logic d6, d2;

  always_comb begin
    en6 = clr_i || flip6_i;
    en2 = clr_i || flip2_i;
    d6  = clr_i ? 1'b0 : !tog6_q;
    d2  = clr_i ? 1'b0 : !tog2_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)  tog6_q <= 1'b0;
    else if (en6) tog6_q <= d6;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)  tog2_q <= 1'b0;
    else if (en2) tog2_q <= d2;
  end

  assign tog6_o = tog6_q;
  assign tog2_o = tog2_q;

  assert_clear_tog_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_i |=> (!tog6_o && !tog2_o));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fstat_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int SECT_W   = 6,
  parameter int BANK_SEL = 2,
  localparam int N_SECT  = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              prog_start_i,
  input  logic              erase_start_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic [N_SECT-1:0] erase_sect_i,
  input  logic              op_done_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              rd_strobe_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ready_o
);
  logic              rst_sn;
  logic              rd_bank, op_bank_in, op_bank;
  logic [SECT_W-1:0] rd_sect, op_sect_unused;
  op_state_t         state;
  logic              prog_bit;
  logic [N_SECT-1:0] sect_mask;
  logic              load;
  logic              tog6, tog2;
  logic              busy_act, bank_hit, sect_hit, use_stat;
  logic              flip6, flip2;
  logic [DATA_W-1:0] stat_word, rd_nx;
  logic [DATA_W-1:0] rd_q;

  fstat_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  fstat_addr_map #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BANK_SEL(BANK_SEL)) u_rd_map (
    .addr_i (rd_addr_i),
    .bank_o (rd_bank),
    .sect_o (rd_sect)
  );

  fstat_addr_map #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BANK_SEL(BANK_SEL)) u_op_map (
    .addr_i (op_addr_i),
    .bank_o (op_bank_in),
    .sect_o (op_sect_unused)
  );

  fstat_ctrl #(.N_SECT(N_SECT)) u_ctrl (
    .clk           (clk),
    .rst_sn        (rst_sn),
    .abort_i       (abort_i),
    .prog_start_i  (prog_start_i),
    .erase_start_i (erase_start_i),
    .op_bank_i     (op_bank_in),
    .prog_bit_i    (prog_data_i[BIT_POLL]),
    .erase_sect_i  (erase_sect_i),
    .op_done_i     (op_done_i),
    .suspend_i     (suspend_i),
    .resume_i      (resume_i),
    .state_o       (state),
    .op_bank_o     (op_bank),
    .prog_bit_o    (prog_bit),
    .sect_mask_o   (sect_mask),
    .load_o        (load),
    .ready_o       (ready_o)
  );

  fstat_toggle u_tog (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .clr_i   (load || abort_i),
    .flip6_i (flip6),
    .flip2_i (flip2),
    .tog6_o  (tog6),
    .tog2_o  (tog2)
  );

  always_comb begin
    busy_act = (state == ST_PROG) || (state == ST_ERASE);
    bank_hit = (rd_bank == op_bank);
    sect_hit = sect_mask[rd_sect];
    use_stat = (busy_act && bank_hit) || ((state == ST_ESUSP) && sect_hit);
    flip6    = rd_strobe_i && busy_act && bank_hit;
    flip2    = rd_strobe_i && sect_hit &&
               (((state == ST_ERASE) && bank_hit) || (state == ST_ESUSP));
  end

  always_comb begin
    stat_word = '0;
    case (state)
      ST_PROG:  stat_word[BIT_POLL] = !prog_bit;
      ST_ESUSP: stat_word[BIT_POLL] = 1'b1;
      default:  stat_word[BIT_POLL] = 1'b0;
    endcase
    stat_word[BIT_TOG]  = tog6;
    stat_word[BIT_ETOG] = (state == ST_PROG) ? 1'b0 : tog2;
    rd_nx = use_stat ? stat_word : array_data_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)          rd_q <= '0;
    else if (rd_strobe_i) rd_q <= rd_nx;
  end

  assign rd_data_o = rd_q;

  assert_other_bank_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_strobe_i && busy_act && !bank_hit) |=> (rd_data_o == $past(array_data_i)));

  assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_strobe_i && state == ST_PROG && bank_hit) |=> (rd_data_o[BIT_POLL] != $past(prog_bit)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_strobe_i |=> $stable(rd_data_o));
endmodule

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          abort_i, prog_start_i, erase_start_i;
  logic [AW-1:0] op_addr_i;
  logic [DW-1:0] prog_data_i;
  logic [NS-1:0] erase_sect_i;
  logic          op_done_i, suspend_i, resume_i, rd_strobe_i;
  logic [AW-1:0] rd_addr_i;
  logic [DW-1:0] array_data_i;
  logic [DW-1:0] rd_data_o;
  logic          ready_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_status_gen u_dut (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
    .prog_start_i(prog_start_i), .erase_start_i(erase_start_i),
    .op_addr_i(op_addr_i), .prog_data_i(prog_data_i), .erase_sect_i(erase_sect_i),
    .op_done_i(op_done_i), .suspend_i(suspend_i), .resume_i(resume_i),
    .rd_strobe_i(rd_strobe_i), .rd_addr_i(rd_addr_i), .array_data_i(array_data_i),
    .rd_data_o(rd_data_o), .ready_o(ready_o)
  );

  function automatic logic [DW-1:0] stw(bit p, bit t6, bit t2);
    logic [DW-1:0] w;
    w = '0;
    w[7] = p;
    w[6] = t6;
    w[2] = t2;
    return w;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_inputs();
    abort_i = 0; prog_start_i = 0; erase_start_i = 0; op_done_i = 0;
    suspend_i = 0; resume_i = 0; rd_strobe_i = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] arr, logic [DW-1:0] exp, string req);
    @(negedge clk);
    rd_strobe_i = 1; rd_addr_i = a; array_data_i = arr;
    tick();
    clear_inputs();
    chk(req, rd_data_o, exp);
  endtask

  task automatic start_prog(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    prog_start_i = 1; op_addr_i = a; prog_data_i = d;
    tick();
    clear_inputs();
  endtask

  task automatic start_erase(logic [AW-1:0] a, logic [NS-1:0] m);
    @(negedge clk);
    erase_start_i = 1; op_addr_i = a; erase_sect_i = m;
    tick();
    clear_inputs();
  endtask

  task automatic pulse_done();
    @(negedge clk); op_done_i = 1; tick(); clear_inputs();
  endtask
  task automatic pulse_susp();
    @(negedge clk); suspend_i = 1; tick(); clear_inputs();
  endtask
  task automatic pulse_resume();
    @(negedge clk); resume_i = 1; tick(); clear_inputs();
  endtask
  task automatic pulse_abort();
    @(negedge clk); abort_i = 1; tick(); clear_inputs();
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", {15'b0, ready_o}, 16'h1);
    rd(21'h01234, 16'hBEEF, 16'hBEEF, "R1 read after reset");
  endtask

  task automatic t_program();
    start_prog(21'h90000, 16'h00F0);
    chk("R7 ready low after program start", {15'b0, ready_o}, 16'h0);
    rd(21'h90010, 16'h5555, stw(0, 0, 0), "R3 R4 first program status");
    rd(21'h90010, 16'h5555, stw(0, 1, 0), "R4 toggle second read");
    rd(21'h7FFFF, 16'h1357, 16'h1357, "R5 R13 other bank below boundary");
    rd(21'h80000, 16'h2468, stw(0, 0, 0), "R13 boundary in busy bank");
    start_prog(21'h90000, 16'h0000);
    chk("R12 ready while restart ignored", {15'b0, ready_o}, 16'h0);
    rd(21'h90000, 16'h9999, stw(0, 1, 0), "R12 restart ignored");
    @(negedge clk);
    rd_strobe_i = 1; rd_addr_i = 21'h90010; array_data_i = 16'h5555; op_done_i = 1;
    tick();
    clear_inputs();
    chk("R8 read with done returns status", rd_data_o, stw(0, 0, 0));
    chk("R7 ready after done", {15'b0, ready_o}, 16'h1);
    rd(21'h90010, 16'h5555, 16'h5555, "R8 array after done");
  endtask

  task automatic t_erase();
    logic [NS-1:0] m;
    m = '0; m[2] = 1; m[3] = 1;
    start_erase(21'h10000, m);
    chk("R7 ready low after erase start", {15'b0, ready_o}, 16'h0);
    rd(21'h10000, 16'hAAAA, stw(0, 0, 0), "R6 first erase status");
    rd(21'h18000, 16'hAAAA, stw(0, 1, 1), "R6 erase toggles");
    rd(21'h28000, 16'h3333, stw(0, 0, 0), "R6 non-erasing sector busy bank");
    rd(21'h10000, 16'hAAAA, stw(0, 1, 0), "R6 erase toggle held");
    rd(21'hA0000, 16'h7777, 16'h7777, "R5 other bank during erase");
    pulse_susp();
    chk("R9 ready in suspend", {15'b0, ready_o}, 16'h1);
    rd(21'h10000, 16'hAAAA, stw(1, 0, 1), "R9 suspended sector status");
    rd(21'h10000, 16'hAAAA, stw(1, 0, 0), "R9 bit6 stable bit2 toggles");
    rd(21'h28000, 16'h3333, 16'h3333, "R9 non-erasing sector array");
    pulse_done();
    chk("R12 done ignored in suspend", {15'b0, ready_o}, 16'h1);
    rd(21'h10000, 16'hAAAA, stw(1, 0, 1), "R12 suspend kept after done");
    pulse_resume();
    chk("R10 ready low after resume", {15'b0, ready_o}, 16'h0);
    rd(21'h18000, 16'hAAAA, stw(0, 0, 0), "R10 status after resume");
    rd(21'h18000, 16'hAAAA, stw(0, 1, 1), "R10 toggle resumes");
    pulse_done();
    chk("R7 ready after erase done", {15'b0, ready_o}, 16'h1);
    rd(21'h10000, 16'hAAAA, 16'hAAAA, "R8 array after erase");
  endtask

  task automatic t_abort();
    logic [NS-1:0] m;
    start_prog(21'h00100, 16'h0000);
    rd(21'h00100, 16'h1111, stw(1, 0, 0), "R3 poll inverse of zero");
    pulse_abort();
    chk("R11 ready after abort", {15'b0, ready_o}, 16'h1);
    rd(21'h00100, 16'h1111, 16'h1111, "R11 array after abort");
    m = '0; m[0] = 1;
    start_erase(21'h00100, m);
    rd(21'h00100, 16'h1111, stw(0, 0, 0), "R4 toggle cleared on start");
    rd(21'h00100, 16'h1111, stw(0, 1, 1), "R6 toggles after restart");
    pulse_abort();
    chk("R11 ready after erase abort", {15'b0, ready_o}, 16'h1);
    rd(21'h00100, 16'h2222, 16'h2222, "R11 array after erase abort");
  endtask

  task automatic t_idle_ignore();
    pulse_done();
    pulse_resume();
    pulse_susp();
    chk("R12 idle controls ignored", {15'b0, ready_o}, 16'h1);
    rd(21'h55555, 16'h4321, 16'h4321, "R12 idle read");
    @(negedge clk);
    rd_strobe_i = 1; rd_addr_i = 21'h90000; array_data_i = 16'h6666;
    prog_start_i = 1; op_addr_i = 21'h90000; prog_data_i = 16'h0080;
    tick();
    clear_inputs();
    chk("R2 read with start returns array", rd_data_o, 16'h6666);
    repeat (3) tick();
    chk("R2 output held without strobe", rd_data_o, 16'h6666);
    pulse_done();
  endtask

  initial begin
    clear_inputs();
    rst_n = 0; op_addr_i = '0; prog_data_i = '0; erase_sect_i = '0;
    rd_addr_i = '0; array_data_i = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_program();
    t_erase();
    t_abort();
    t_idle_ignore();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule